// File: doc/BRIEF.md
# Program Counter and Memory Address Selector

This block holds the program counter and the memory address register of a 16-bit machine whose address space has 65,536 locations, each one word wide. On every clock edge it can load the PC from one of four candidates: the next sequential address, a paged direct target, a register-file value, or the value on the shared bus. In the same edge it can load the MAR from one of three address forms: a paged direct address, a base register plus a small unsigned offset, or a zero-extended trap vector.

A paged target keeps the upper seven bits of the PC as it stands and replaces the low nine bits with the low nine bits of the instruction register. Because the PC has already been incremented by fetch time, the page is the one holding the next instruction. A paged target never leaves its 512-word page. The base-plus-offset form adds a six-bit unsigned field to a register value and wraps modulo 2^16, so it can reach any location. Control supplies the selects and a separate load enable for each register. All pins are plain control and data levels with no handshake. A register whose enable is low keeps its value.

Top module: `pc_mar_unit`

## Requirements
- R1: While `rst_n` is low, `pc_q` is 16'h3000 and `mar_q` is 16'h0000.
- R2: With `pc_ld` high and `pc_sel` = 0, the PC becomes PC+1 at the next edge, and 16'hFFFF is followed by 16'h0000.
- R3: With `pc_ld` high and `pc_sel` = 1, the PC becomes {PC[15:9], ir[8:0]}. The result stays on the current 512-word page, even when PC is the last word of that page.
- R4: With `pc_ld` high and `pc_sel` = 2, the PC becomes `rf_val`.
- R5: With `pc_ld` high and `pc_sel` = 3, the PC becomes `bus_val`.
- R6: With `pc_ld` low, the PC keeps its value whatever the selects and data inputs do.
- R7: With `mar_ld` high and `mar_sel` = 0, the MAR becomes {PC[15:9], ir[8:0]}.
- R8: With `mar_ld` high and `mar_sel` = 1, the MAR becomes `rf_val` plus zero-extended ir[5:0], modulo 2^16.
- R9: With `mar_ld` high and `mar_sel` = 2, the MAR becomes zero-extended ir[7:0]. Bits 15:8 are zero whatever ir[15:8] holds.
- R10: With `mar_ld` high and `mar_sel` = 3, the MAR becomes 16'h0000.
- R11: With `mar_ld` low, the MAR keeps its value.
- R12: When both registers load on the same edge, the MAR page bits come from the PC value held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir | input | 16 | Instruction register contents |
| rf_val | input | 16 | Register-file read value |
| bus_val | input | 16 | Shared bus value |
| pc_sel | input | 2 | PC source: 0 sequential, 1 paged, 2 register, 3 bus |
| pc_ld | input | 1 | PC load enable |
| mar_sel | input | 2 | MAR source: 0 paged, 1 base+offset, 2 trap vector, 3 zero |
| mar_ld | input | 1 | MAR load enable |
| pc_q | output | 16 | Program counter |
| mar_q | output | 16 | Memory address register |

## Verification
The bench parks the PC on the last word of a page (16'h31FF) and takes a paged target from there. A design that formed the target by addition or carried into bit 9 would jump to the next page. It sends trap vectors 8'h21, 8'h23 and 8'h25 with the upper instruction bits set. A design that sign-extended or passed through ir[15:8] would show nonzero upper MAR bits. It also checks the PC wrapping from FFFF to 0000 and a base-plus-offset sum that overflows. It loads both registers on the same edge, which catches a MAR that reads the PC's new value instead of the value held before the edge.

// File: rtl/pc_mar_pkg.sv
package pc_mar_pkg;
  typedef enum logic [1:0] {
    PCS_SEQ  = 2'd0,
    PCS_PAGE = 2'd1,
    PCS_REG  = 2'd2,
    PCS_BUS  = 2'd3
  } pc_src_e;

  typedef enum logic [1:0] {
    MAS_PAGE = 2'd0,
    MAS_BASE = 2'd1,
    MAS_TRAP = 2'd2,
    MAS_ZERO = 2'd3
  } mar_src_e;
endpackage

// File: rtl/addr_reg.sv
module addr_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/page_join.sv
module page_join #(
  parameter int W      = 16,
  parameter int PAGE_W = 9
) (
  input  logic [W-1:0]      cur_pc,
  input  logic [PAGE_W-1:0] ofs,
  output logic [W-1:0]      tgt
);
  // Upper page bits from the PC, low bits from the instruction; no carry path.
  assign tgt = {cur_pc[W-1:PAGE_W], ofs};
endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
  import pc_mar_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] cur_pc,
  input  logic [W-1:0] page_tgt,
  input  logic [W-1:0] rf_val,
  input  logic [W-1:0] bus_val,
  input  logic [1:0]   sel,
  output logic [W-1:0] nxt
);
  logic [W-1:0] seq_pc;
  assign seq_pc = cur_pc + W'(1);

  always_comb begin
    unique case (pc_src_e'(sel))
      PCS_SEQ:  nxt = seq_pc;
      PCS_PAGE: nxt = page_tgt;
      PCS_REG:  nxt = rf_val;
      PCS_BUS:  nxt = bus_val;
      default:  nxt = seq_pc;
    endcase
  end
endmodule

// File: rtl/mar_src_sel.sv
module mar_src_sel
  import pc_mar_pkg::*;
#(
  parameter int W      = 16,
  parameter int OFS_W  = 6,
  parameter int TRAP_W = 8
) (
  input  logic [W-1:0]      page_tgt,
  input  logic [W-1:0]      rf_val,
  input  logic [OFS_W-1:0]  base_ofs,
  input  logic [TRAP_W-1:0] trap_vec,
  input  logic [1:0]        sel,
  output logic [W-1:0]      addr
);
  logic [W-1:0] base_sum;
  logic [W-1:0] trap_addr;

  // Unsigned offset, sum truncated to W bits (wraps modulo 2^W).
  assign base_sum  = rf_val + W'(base_ofs);
  assign trap_addr = W'(trap_vec);

  always_comb begin
    unique case (mar_src_e'(sel))
      MAS_PAGE: addr = page_tgt;
      MAS_BASE: addr = base_sum;
      MAS_TRAP: addr = trap_addr;
      MAS_ZERO: addr = '0;
      default:  addr = '0;
    endcase
  end
endmodule

// File: rtl/pc_mar_unit.sv
module pc_mar_unit #(
  parameter int W      = 16,
  parameter int PAGE_W = 9,
  parameter int OFS_W  = 6,
  parameter int TRAP_W = 8,
  parameter logic [W-1:0] PC_RESET = 16'h3000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ir,
  input  logic [W-1:0] rf_val,
  input  logic [W-1:0] bus_val,
  input  logic [1:0]   pc_sel,
  input  logic         pc_ld,
  input  logic [1:0]   mar_sel,
  input  logic         mar_ld,
  output logic [W-1:0] pc_q,
  output logic [W-1:0] mar_q
);
  localparam int IR_USED = (PAGE_W > TRAP_W) ? ((PAGE_W > OFS_W) ? PAGE_W : OFS_W)
                                             : ((TRAP_W > OFS_W) ? TRAP_W : OFS_W);

  logic [W-1:0] page_tgt;
  logic [W-1:0] pc_d;
  logic [W-1:0] mar_d;

  generate
    if (IR_USED < W) begin : g_ir_hi
      logic unused_ir_hi;
      assign unused_ir_hi = ^ir[W-1:IR_USED];
    end
  endgenerate

  page_join #(.W(W), .PAGE_W(PAGE_W)) u_page (
    .cur_pc (pc_q),
    .ofs    (ir[PAGE_W-1:0]),
    .tgt    (page_tgt)
  );

  pc_next_sel #(.W(W)) u_pcsel (
    .cur_pc   (pc_q),
    .page_tgt (page_tgt),
    .rf_val   (rf_val),
    .bus_val  (bus_val),
    .sel      (pc_sel),
    .nxt      (pc_d)
  );

  mar_src_sel #(.W(W), .OFS_W(OFS_W), .TRAP_W(TRAP_W)) u_marsel (
    .page_tgt (page_tgt),
    .rf_val   (rf_val),
    .base_ofs (ir[OFS_W-1:0]),
    .trap_vec (ir[TRAP_W-1:0]),
    .sel      (mar_sel),
    .addr     (mar_d)
  );

  addr_reg #(.W(W), .RST_VAL(PC_RESET)) u_pc (
    .clk (clk), .rst_n (rst_n), .ld (pc_ld), .d (pc_d), .q (pc_q)
  );

  addr_reg #(.W(W), .RST_VAL('0)) u_mar (
    .clk (clk), .rst_n (rst_n), .ld (mar_ld), .d (mar_d), .q (mar_q)
  );
endmodule

// File: rtl/pc_mar_chk.sv
module pc_mar_chk #(
  parameter int W      = 16,
  parameter int PAGE_W = 9,
  parameter int OFS_W  = 6,
  parameter int TRAP_W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] ir,
  input logic [W-1:0] rf_val,
  input logic [W-1:0] bus_val,
  input logic [1:0]   pc_sel,
  input logic         pc_ld,
  input logic [1:0]   mar_sel,
  input logic         mar_ld,
  input logic [W-1:0] pc_q,
  input logic [W-1:0] mar_q
);
  // R2
  pc_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_ld && pc_sel == 2'd0) |=> pc_q == $past(pc_q) + W'(1));
  // R3
  pc_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_ld && pc_sel == 2'd1) |=>
      (pc_q[W-1:PAGE_W] == $past(pc_q[W-1:PAGE_W]) && pc_q[PAGE_W-1:0] == $past(ir[PAGE_W-1:0])));
  // R4
  pc_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_ld && pc_sel == 2'd2) |=> pc_q == $past(rf_val));
  // R5
  pc_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_ld && pc_sel == 2'd3) |=> pc_q == $past(bus_val));
  // R6
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_ld |=> $stable(pc_q));
  // R7 R12
  mar_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mar_ld && mar_sel == 2'd0) |=>
      (mar_q[W-1:PAGE_W] == $past(pc_q[W-1:PAGE_W]) && mar_q[PAGE_W-1:0] == $past(ir[PAGE_W-1:0])));
  // R8
  mar_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mar_ld && mar_sel == 2'd1) |=> mar_q == $past(rf_val) + W'($past(ir[OFS_W-1:0])));
  // R9
  mar_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mar_ld && mar_sel == 2'd2) |=>
      (mar_q[W-1:TRAP_W] == '0 && mar_q[TRAP_W-1:0] == $past(ir[TRAP_W-1:0])));
  // R10
  mar_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mar_ld && mar_sel == 2'd3) |=> mar_q == '0);
  // R11
  mar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mar_ld |=> $stable(mar_q));
  // R1
  always_comb begin
    if (!rst_n) begin
      rst_val_chk: assert (mar_q == '0 || $isunknown(mar_q));
    end
  end

  logic unused_bus;
  assign unused_bus = ^bus_val;
endmodule

bind pc_mar_unit pc_mar_chk #(.W(W), .PAGE_W(PAGE_W), .OFS_W(OFS_W), .TRAP_W(TRAP_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .ir (ir), .rf_val (rf_val), .bus_val (bus_val),
  .pc_sel (pc_sel), .pc_ld (pc_ld), .mar_sel (mar_sel), .mar_ld (mar_ld),
  .pc_q (pc_q), .mar_q (mar_q)
);

// File: tb/sim_pc_mar_unit.sv
module sim_pc_mar_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ir = '0, rf_val = '0, bus_val = '0;
  logic [1:0]  pc_sel = '0, mar_sel = '0;
  logic        pc_ld = 1'b0, mar_ld = 1'b0;
  logic [15:0] pc_q, mar_q;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pc_mar_unit u0 (
    .clk (clk), .rst_n (rst_n), .ir (ir), .rf_val (rf_val), .bus_val (bus_val),
    .pc_sel (pc_sel), .pc_ld (pc_ld), .mar_sel (mar_sel), .mar_ld (mar_ld),
    .pc_q (pc_q), .mar_q (mar_q)
  );

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive at negedge, let one rising edge load, sample at the following negedge.
  task automatic step(logic pl, logic [1:0] ps, logic ml, logic [1:0] ms,
                      logic [15:0] i, logic [15:0] r, logic [15:0] b);
    pc_ld = pl; pc_sel = ps; mar_ld = ml; mar_sel = ms;
    ir = i; rf_val = r; bus_val = b;
    @(posedge clk);
    @(negedge clk);
    pc_ld = 1'b0; mar_ld = 1'b0;
  endtask

  task automatic set_pc(logic [15:0] v);
    step(1'b1, 2'd3, 1'b0, 2'd0, 16'h0, 16'h0, v);
  endtask

  task automatic t_reset;
    check("R1 pc", pc_q, 16'h3000);
    check("R1 mar", mar_q, 16'h0000);
  endtask

  task automatic t_seq;
    step(1'b1, 2'd0, 1'b0, 2'd0, 16'h0, 16'h0, 16'h0);
    check("R2 inc", pc_q, 16'h3001);
    set_pc(16'hFFFF);
    check("R5 bus", pc_q, 16'hFFFF);
    step(1'b1, 2'd0, 1'b0, 2'd0, 16'h0, 16'h0, 16'h0);
    check("R2 wrap", pc_q, 16'h0000);
  endtask

  task automatic t_page;
    set_pc(16'h31FF);
    step(1'b1, 2'd1, 1'b0, 2'd0, 16'hFE05, 16'h0, 16'h0);
    check("R3 page at boundary", pc_q, 16'h3005);
    set_pc(16'h31FF);
    step(1'b1, 2'd1, 1'b0, 2'd0, 16'h01FF, 16'h0, 16'h0);
    check("R3 last word", pc_q, 16'h31FF);
    step(1'b1, 2'd0, 1'b0, 2'd0, 16'h0, 16'h0, 16'h0);
    step(1'b1, 2'd1, 1'b0, 2'd0, 16'h0010, 16'h0, 16'h0);
    check("R3 next page", pc_q, 16'h3210);
  endtask

  task automatic t_reg_hold;
    step(1'b1, 2'd2, 1'b0, 2'd0, 16'h0, 16'hA5C3, 16'h1111);
    check("R4 reg", pc_q, 16'hA5C3);
    step(1'b0, 2'd3, 1'b0, 2'd0, 16'hFFFF, 16'h1234, 16'h5678);
    check("R6 hold", pc_q, 16'hA5C3);
    check("R11 hold", mar_q, 16'h0000);
  endtask

  task automatic t_mar;
    set_pc(16'h4A10);
    step(1'b0, 2'd0, 1'b1, 2'd0, 16'hC0AB, 16'h0, 16'h0);
    check("R7 page", mar_q, 16'h4AAB);
    step(1'b0, 2'd0, 1'b1, 2'd1, 16'hFFE5, 16'h1000, 16'h0);
    check("R8 base", mar_q, 16'h1025);
    step(1'b0, 2'd0, 1'b1, 2'd1, 16'hFFFF, 16'hFFFC, 16'h0);
    check("R8 wrap", mar_q, 16'h003B);
    step(1'b0, 2'd0, 1'b0, 2'd2, 16'hFF21, 16'h0, 16'h0);
    check("R11 no load", mar_q, 16'h003B);
    step(1'b0, 2'd0, 1'b1, 2'd2, 16'hFF21, 16'h0, 16'h0);
    check("R9 trap21", mar_q, 16'h0021);
    step(1'b0, 2'd0, 1'b1, 2'd2, 16'hF023, 16'h0, 16'h0);
    check("R9 trap23", mar_q, 16'h0023);
    step(1'b0, 2'd0, 1'b1, 2'd2, 16'h8025, 16'h0, 16'h0);
    check("R9 trap25", mar_q, 16'h0025);
    step(1'b0, 2'd0, 1'b1, 2'd3, 16'hFFFF, 16'hFFFF, 16'h0);
    check("R10 zero", mar_q, 16'h0000);
    check("R6 pc untouched", pc_q, 16'h4A10);
  endtask

  task automatic t_same_edge;
    set_pc(16'h53FF);
    step(1'b1, 2'd0, 1'b1, 2'd0, 16'h0077, 16'h0, 16'h0);
    check("R12 pc", pc_q, 16'h5400);
    check("R12 mar old page", mar_q, 16'h5277);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seq();
    t_page();
    t_reg_hold();
    t_mar();
    t_same_edge();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule